// File: doc/BRIEF.md
# Bang-Bang PLL Digital Loop Filter

This block turns the one-bit early/late decision of a flip-flop phase detector into a signed tuning word for a digitally controlled oscillator. On every rising edge of the reference clock it maps the decision to an error of +1 or -1. The error drives two paths. A proportional path adds alpha times the error. An integral path keeps a saturating sum of beta times the error. The sum of the two paths can then pass through a chain of one-pole low-pass sections, each of which can be bypassed. The filtered deviation is added to a programmable centre word, and the result is clamped to the output width.

The loop starts in a wide-gain acquisition mode so that lock is reached quickly. Once the detector output has toggled on a run of consecutive reference edges, the loop is taken as locked. From then on both gains are divided by a programmable power of two, which lowers jitter. Acquisition is chosen at reset by a control input, and it ends only once, on its own.

Top module: `bbpll_loop_filter`

## Requirements
- R1: While reset is asserted at a rising edge, the tuning word becomes the centre word. The integral sum and every smoothing state become zero, and `acq_active` takes the value of `acq_en`.
- R2: `pd_lead`=1 (reference leads) is taken as error +1 and `pd_lead`=0 as error -1. With all smoothing sections bypassed, the tuning word is centre + integral + error×proportional gain, where the integral has already absorbed the current error×integral gain.
- R3: The integral sum saturates at the signed limits of the W-bit tuning word (for W=16: -32768 and 32767) and never wraps.
- R4: The sum of the centre word and the filtered deviation is clamped to the signed W-bit range.
- R5: Smoothing section i, when enabled, updates y := y + ((x - y) >>> k), using an arithmetic shift that rounds toward minus infinity. Here k is `iir_k[3i+2:3i]`, in the range 0 to 7. The sections are applied in order, from section 0 up to section NIIR-1.
- R6: When bit i of `iir_en` is 0, section i passes its input straight through and its state follows the input.
- R7: In acquisition mode, the mode ends at the edge that samples the 32nd consecutive sample that differs from the previous sample. `acq_active` falls after that edge, and tracking mode then stays until the next reset.
- R8: A sample equal to the previous one restarts the toggle count. The first sample after reset counts as no toggle.
- R9: Acquisition uses `alpha` and `beta` as given. Tracking uses `alpha >> lock_shift` and `beta >> lock_shift`, with a logical shift of 0 to 7.
- R10: The tuning word is registered. It reflects the detector bit sampled at the most recent rising edge, so the latency is one cycle.
- R11: With `acq_en`=0 at reset, the loop runs in tracking mode from the first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one filter update per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pd_lead | input | 1 | Phase decision: 1 reference leads, 0 reference lags |
| alpha | input | CW | Unsigned proportional gain |
| beta | input | CW | Unsigned integral gain |
| lock_shift | input | 3 | Gain reduction shift applied in tracking mode |
| acq_en | input | 1 | Start in acquisition mode after reset |
| iir_en | input | NIIR | Per-section enable of the smoothing chain |
| iir_k | input | 3*NIIR | Per-section shift, 3 bits per section |
| center | input | W | Signed centre tuning word |
| tune_word | output | W | Signed oscillator tuning word |
| acq_active | output | 1 | High while in acquisition mode |

## Verification
Each detector bit is applied half a cycle before a rising edge. Both the tuning word and the mode flag change at that edge. The bench sets the bit at a falling edge, moves its own model forward by one update, and compares the outputs at the following falling edge. Each comparison therefore falls exactly one edge after the stimulus it belongs to. Reset values are compared at the first falling edge after a reset edge. The mode change is checked on the sample that completes the toggle run and on the sample before it.

// File: rtl/bbpll_lf_pkg.sv
package bbpll_lf_pkg;

    typedef enum logic {
        MODE_TRACK = 1'b0,
        MODE_ACQ   = 1'b1
    } lf_mode_e;

    localparam int DEF_TUNE_W  = 16;
    localparam int DEF_COEF_W  = 12;
    localparam int DEF_NIIR    = 4;
    localparam int DEF_LOCK_RUN = 32;

    // clamp a wide signed value into [lo, hi]
    function automatic logic signed [63:0] clamp64(
        input logic signed [63:0] v,
        input logic signed [63:0] lo,
        input logic signed [63:0] hi
    );
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/bbpll_lf_gain.sv
module bbpll_lf_gain
    import bbpll_lf_pkg::*;
#(
    parameter int CW       = DEF_COEF_W,
    parameter int LOCK_RUN = DEF_LOCK_RUN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_lead,
    input  logic          acq_en,
    input  logic [CW-1:0] alpha,
    input  logic [CW-1:0] beta,
    input  logic [2:0]    lock_shift,
    output logic [CW-1:0] a_gain,
    output logic [CW-1:0] b_gain,
    output lf_mode_e      mode
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);

    lf_mode_e    mode_q;
    logic [RW-1:0] run_q;
    logic        prev_q;
    logic        have_prev_q;
    logic        toggled;

    assign toggled = have_prev_q && (pd_lead != prev_q);
    assign mode    = mode_q;

    always_comb begin
        if (mode_q == MODE_ACQ) begin
            a_gain = alpha;
            b_gain = beta;
        end else begin
            a_gain = alpha >> lock_shift;
            b_gain = beta >> lock_shift;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= acq_en ? MODE_ACQ : MODE_TRACK;
            run_q       <= '0;
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
        end else begin
            prev_q      <= pd_lead;
            have_prev_q <= 1'b1;
            if (mode_q == MODE_ACQ) begin
                if (toggled) begin
                    if (run_q == RUN_LAST) begin
                        mode_q <= MODE_TRACK;
                    end
                    run_q <= run_q + 1'b1;
                end else begin
                    run_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bbpll_lf_pi.sv
module bbpll_lf_pi
    import bbpll_lf_pkg::*;
#(
    parameter int W  = DEF_TUNE_W,
    parameter int CW = DEF_COEF_W,
    parameter int DW = W + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pd_lead,
    input  logic [CW-1:0]        a_gain,
    input  logic [CW-1:0]        b_gain,
    output logic signed [DW-1:0] acc,
    output logic signed [DW-1:0] pi_out
);
    localparam logic signed [63:0] LIM_HI = (64'sd1 <<< (W - 1)) - 64'sd1;
    localparam logic signed [63:0] LIM_LO = -(64'sd1 <<< (W - 1));

    logic signed [DW-1:0] acc_q;
    logic signed [DW-1:0] a_ext;
    logic signed [DW-1:0] b_ext;
    logic signed [DW-1:0] acc_nx;
    logic signed [63:0]   acc_raw;

    assign a_ext = signed'({{(DW-CW){1'b0}}, a_gain});
    assign b_ext = signed'({{(DW-CW){1'b0}}, b_gain});

    always_comb begin
        acc_raw = 64'(acc_q) + (pd_lead ? 64'(b_ext) : -64'(b_ext));
        acc_nx  = DW'(clamp64(acc_raw, LIM_LO, LIM_HI));
        pi_out  = pd_lead ? (acc_nx + a_ext) : (acc_nx - a_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_nx;
    end

    assign acc = acc_q;
endmodule

// File: rtl/bbpll_lf_iir.sv
module bbpll_lf_iir #(
    parameter int DW = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [2:0]           k,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y
);
    logic signed [DW-1:0] y_q;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] y_nx;

    always_comb begin
        diff = x - y_q;
        y_nx = en ? (y_q + (diff >>> k)) : x;
    end

    always_ff @(posedge clk) begin
        if (rst) y_q <= '0;
        else     y_q <= y_nx;
    end

    assign y = y_nx;
endmodule

// File: rtl/bbpll_loop_filter.sv
module bbpll_loop_filter
    import bbpll_lf_pkg::*;
#(
    parameter int W        = DEF_TUNE_W,
    parameter int CW       = DEF_COEF_W,
    parameter int NIIR     = DEF_NIIR,
    parameter int LOCK_RUN = DEF_LOCK_RUN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pd_lead,
    input  logic [CW-1:0]       alpha,
    input  logic [CW-1:0]       beta,
    input  logic [2:0]          lock_shift,
    input  logic                acq_en,
    input  logic [NIIR-1:0]     iir_en,
    input  logic [3*NIIR-1:0]   iir_k,
    input  logic signed [W-1:0] center,
    output logic signed [W-1:0] tune_word,
    output logic                acq_active
);
    localparam int DW = W + 3;
    localparam logic signed [63:0] OUT_HI = (64'sd1 <<< (W - 1)) - 64'sd1;
    localparam logic signed [63:0] OUT_LO = -(64'sd1 <<< (W - 1));

    logic [CW-1:0]        a_gain;
    logic [CW-1:0]        b_gain;
    lf_mode_e             mode;
    logic signed [DW-1:0] acc_q;
    logic signed [DW-1:0] chain [NIIR+1];
    logic signed [W-1:0]  tune_q;
    logic signed [W-1:0]  tune_nx;

    bbpll_lf_gain #(.CW(CW), .LOCK_RUN(LOCK_RUN)) u_gain (
        .clk(clk), .rst(rst), .pd_lead(pd_lead), .acq_en(acq_en),
        .alpha(alpha), .beta(beta), .lock_shift(lock_shift),
        .a_gain(a_gain), .b_gain(b_gain), .mode(mode)
    );

    bbpll_lf_pi #(.W(W), .CW(CW), .DW(DW)) u_pi (
        .clk(clk), .rst(rst), .pd_lead(pd_lead),
        .a_gain(a_gain), .b_gain(b_gain),
        .acc(acc_q), .pi_out(chain[0])
    );

    for (genvar i = 0; i < NIIR; i++) begin : g_iir
        bbpll_lf_iir #(.DW(DW)) u_sec (
            .clk(clk), .rst(rst), .en(iir_en[i]), .k(iir_k[3*i +: 3]),
            .x(chain[i]), .y(chain[i+1])
        );
    end

    assign tune_nx = W'(clamp64(64'(center) + 64'(chain[NIIR]), OUT_LO, OUT_HI));

    always_ff @(posedge clk) begin
        if (rst) tune_q <= center;
        else     tune_q <= tune_nx;
    end

    assign tune_word  = tune_q;
    assign acq_active = (mode == MODE_ACQ);
endmodule

// File: rtl/bbpll_lf_chk.sv
module bbpll_lf_chk #(
    parameter int W  = 16,
    parameter int CW = 12,
    parameter int DW = W + 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pd_lead,
    input logic                 acq_en,
    input logic                 acq_active,
    input logic signed [DW-1:0] acc_q
);
    localparam logic signed [DW-1:0] STEP_MAX = DW'((1 << CW) - 1);
    localparam logic signed [DW-1:0] ACC_HI   = DW'((1 << (W - 1)) - 1);
    localparam logic signed [DW-1:0] ACC_LO   = -DW'(1 << (W - 1));

    // R7: tracking mode is sticky until reset
    a_r7_track_sticky: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !acq_active) |=> !acq_active);

    // R8: the mode only falls right after a toggling sample
    a_r8_fall_on_toggle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(acq_active)) |-> ($past(pd_lead) != $past(pd_lead, 2)));

    // R3: integral moves by at most one gain step per cycle, no wrap
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((acc_q - $past(acc_q)) <= STEP_MAX &&
                         (acc_q - $past(acc_q)) >= -STEP_MAX));

    // R3: integral stays within the tuning word range
    a_r3_acc_range: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (acc_q <= ACC_HI && acc_q >= ACC_LO));

    // R11: no acquisition when it was not requested at reset
    a_r11_no_acq: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(acq_en)) |-> !acq_active);
endmodule

bind bbpll_loop_filter bbpll_lf_chk #(.W(W), .CW(CW), .DW(W + 3)) u_chk (
    .clk(clk), .rst(rst), .pd_lead(pd_lead), .acq_en(acq_en),
    .acq_active(acq_active), .acc_q(acc_q)
);

// File: tb/bbpll_loop_filter_test.sv
module bbpll_loop_filter_test;
    localparam int W = 16, CW = 12, NIIR = 4;
    localparam longint HI = (64'sd1 <<< (W - 1)) - 1;
    localparam longint LO = -(64'sd1 <<< (W - 1));

    logic clk = 1'b0, rst = 1'b1, pd_lead = 1'b0, acq_en = 1'b1;
    logic [CW-1:0] alpha = '0, beta = '0;
    logic [2:0] lock_shift = '0;
    logic [NIIR-1:0] iir_en = '0;
    logic [3*NIIR-1:0] iir_k = '0;
    logic signed [W-1:0] center = '0;
    logic signed [W-1:0] tune_word;
    logic acq_active;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // model state
    longint m_acc, m_y [NIIR], m_out;
    int m_run;
    bit m_prev, m_have, m_acq;

    always #10 clk = ~clk;

    bbpll_loop_filter #(.W(W), .CW(CW), .NIIR(NIIR)) uut (
        .clk(clk), .rst(rst), .pd_lead(pd_lead), .alpha(alpha), .beta(beta),
        .lock_shift(lock_shift), .acq_en(acq_en), .iir_en(iir_en), .iir_k(iir_k),
        .center(center), .tune_word(tune_word), .acq_active(acq_active)
    );

    function automatic longint sat(longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step(bit pd);
        longint a, b, e, x;
        a = m_acq ? longint'(alpha) : longint'(alpha >> lock_shift);
        b = m_acq ? longint'(beta)  : longint'(beta >> lock_shift);
        e = pd ? 1 : -1;
        m_acc = sat(m_acc + e * b);
        x = m_acc + e * a;
        for (int i = 0; i < NIIR; i++) begin
            if (iir_en[i]) m_y[i] = m_y[i] + ((x - m_y[i]) >>> iir_k[3*i +: 3]);
            else           m_y[i] = x;
            x = m_y[i];
        end
        m_out = sat(longint'(center) + x);
        if (m_acq) begin
            if (m_have && pd != m_prev) begin
                m_run++;
                if (m_run == 32) m_acq = 0;
            end else begin
                m_run = 0;
            end
        end
        m_prev = pd;
        m_have = 1;
    endtask

    task automatic do_reset(bit acq);
        acq_en = acq;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_acc = 0; m_run = 0; m_have = 0; m_prev = 0; m_acq = acq;
        for (int i = 0; i < NIIR; i++) m_y[i] = 0;
        m_out = longint'(center);
        check("R1 reset tune", longint'(tune_word), longint'(center));
        check("R1 reset mode", longint'(acq_active), longint'(acq));
    endtask

    // drive one sample, compare one edge later (R10)
    task automatic cycle(bit pd, string req);
        pd_lead = pd;
        model_step(pd);
        @(negedge clk);
        check(req, longint'(tune_word), m_out);
        check(req, longint'(acq_active), longint'(m_acq));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);

        // R1, R2, R9, R10, R11: tracking from start, divided gains
        center = 16'sd1000; alpha = 12'd40; beta = 12'd8; lock_shift = 3'd2;
        do_reset(1'b0);
        cycle(1'b1, "R2 R9 R11 lead");
        check("R2 R9 lead value", longint'(tune_word), 64'd1012);
        cycle(1'b0, "R2 lag");
        check("R2 lag value", longint'(tune_word), 64'd990);

        // R3: integral saturation, no wrap
        center = '0; alpha = '0; beta = 12'd4095; lock_shift = '0;
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) cycle(1'b1, "R3 ramp");
        check("R3 saturated", longint'(tune_word), 64'd32767);
        cycle(1'b0, "R3 back");
        check("R3 no wrap", longint'(tune_word), 64'd28672);
        for (int i = 0; i < 20; i++) cycle(1'b0, "R3 down");
        check("R3 low limit", longint'(tune_word), -64'd32768);

        // R4: output clamp with large centre
        center = 16'sd30000; beta = 12'd2000; alpha = 12'd100;
        do_reset(1'b0);
        cycle(1'b1, "R4 step");
        check("R4 value", longint'(tune_word), 64'd32100);
        cycle(1'b1, "R4 clamp");
        check("R4 clamped", longint'(tune_word), 64'd32767);

        // R5, R6: one enabled section k=1, others bypassed
        center = '0; alpha = 12'd64; beta = '0; iir_en = 4'b0001; iir_k = 12'h001;
        do_reset(1'b0);
        cycle(1'b1, "R5 first");
        check("R5 half step", longint'(tune_word), 64'd32);
        cycle(1'b1, "R5 second");
        check("R5 quarter step", longint'(tune_word), 64'd48);
        iir_en = 4'b0000;
        cycle(1'b1, "R6 bypass");
        check("R6 bypass value", longint'(tune_word), 64'd64);

        // R7: 32 toggles end acquisition
        alpha = 12'd16; beta = 12'd4; lock_shift = 3'd2; iir_en = '0;
        do_reset(1'b1);
        cycle(1'b0, "R7 first");
        for (int i = 1; i <= 31; i++) cycle(1'(i & 1), "R7 toggles");
        check("R7 still acq at 31", longint'(acq_active), 64'd1);
        cycle(1'b0, "R7 32nd");
        check("R7 tracking at 32", longint'(acq_active), 64'd0);
        cycle(1'b0, "R7 sticky");
        cycle(1'b1, "R9 narrowed gain");

        // R8: repeat restarts run
        do_reset(1'b1);
        cycle(1'b0, "R8 first");
        for (int i = 1; i <= 20; i++) cycle(1'(i & 1), "R8 toggles");
        cycle(1'b0, "R8 repeat");
        for (int i = 1; i <= 31; i++) cycle(1'(i & 1), "R8 rerun");
        check("R8 still acq", longint'(acq_active), 64'd1);
        cycle(1'b0, "R8 end");
        check("R8 tracking", longint'(acq_active), 64'd0);

        // random blocks: all requirements against the model
        for (int blk = 0; blk < 8; blk++) begin
            center = W'($urandom_range(0, 65535));
            alpha = CW'($urandom); beta = CW'($urandom_range(0, 255));
            lock_shift = 3'($urandom); iir_en = NIIR'($urandom); iir_k = 12'($urandom);
            do_reset(1'($urandom));
            for (int c = 0; c < 400; c++) begin
                bit p;
                if (c < 60) p = 1'(c & 1) ^ (($urandom_range(0, 15) == 0) ? 1'b1 : 1'b0);
                else        p = 1'($urandom);
                cycle(p, "R5 R9 random");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule